// File: doc/BRIEF.md
# Multi-Port Distributed Lookup RAM

This block models a small lookup-table memory of 64 words, each word `W` bits wide. It is built from `W` independent 64x1 bit lanes that share every address. Port A is the only writer. On a rising clock edge with its write enable high, it stores `din_a` at `addr_a`. Port A also reads. Ports B, C and D are read-only, and each one has an address of its own. Every read is combinational: a read output follows its address without waiting for a clock edge.

A static two-bit configuration input sets how many read ports are live. Single-port uses A alone. Dual-port uses A and B. Quad-port uses all four. The configuration only gates the read outputs. Stored contents are not touched when it changes. The store has no reset, so a word is undefined until it has been written.

Top module: `lutram_multiport`

## Requirements
- R1: The store holds 64 independent words. Writing a distinct value to every address and then reading all of them returns each value at its own address.
- R2: On a rising edge of `clk` with `we_a` = 1, `din_a` is stored at `addr_a`. The new word is visible on every live port addressing it right after that edge.
- R3: While `we_a` = 0, rising edges leave the contents unchanged, whatever `din_a` and `addr_a` are.
- R4: Read outputs are combinational. When a read address changes between clock edges, its output shows the addressed word before the next edge.
- R5: When a read port addresses the word being written, it shows the old word until the edge and the new word after it.
- R6: `cfg` = 2'b00 (single): only port A is live. `dout_b`, `dout_c` and `dout_d` are 0 whatever their addresses.
- R7: `cfg` = 2'b01 (dual): ports A and B are live. `dout_c` and `dout_d` are 0.
- R8: `cfg` = 2'b10 (quad): all four ports read independently, each at its own address.
- R9: `cfg` = 2'b11 behaves as single-port: B, C and D read 0.
- R10: Bit lanes are independent. Bit i of every read output comes only from bit i of earlier writes.
- R11: Changing `cfg` does not alter the stored contents. It only selects which outputs are live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| cfg | input | 2 | Port configuration (00 single, 01 dual, 10 quad, 11 single) |
| we_a | input | 1 | Write enable for port A, active high |
| addr_a | input | AW (6) | Port A write/read address |
| din_a | input | W | Port A write data |
| dout_a | output | W | Port A read data |
| addr_b | input | AW (6) | Port B read address |
| dout_b | output | W | Port B read data |
| addr_c | input | AW (6) | Port C read address |
| dout_c | output | W | Port C read data |
| addr_d | input | AW (6) | Port D read address |
| dout_d | output | W | Port D read data |

## Verification
The hardest case to reach is a read-only port that addresses the word port A is writing in that same cycle. The check needs to see the old value before the edge and the new one after it. The stimulus sets the write and the matching read address on the falling edge and samples before the rising edge. It then samples again just after the edge, using a new value that is the complement of the old one, so that every lane changes.

Each configuration is also swept over all 64 addresses. The four read addresses are scrambled differently for each port, so a port that reads the wrong address or picks up another port's address gives a mismatch.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

    localparam int unsigned NUM_PORTS = 4;

    typedef enum logic [1:0] {
        CFG_SINGLE     = 2'b00,
        CFG_DUAL       = 2'b01,
        CFG_QUAD       = 2'b10,
        CFG_SINGLE_ALT = 2'b11
    } cfg_e;

    // Port index 0 is A, 1 is B, 2 is C, 3 is D.
    function automatic logic port_live(cfg_e cfg, int unsigned idx);
        logic live;
        if (idx == 0) begin
            live = 1'b1;
        end else begin
            case (cfg)
                CFG_DUAL: live = (idx == 1);
                CFG_QUAD: live = 1'b1;
                default:  live = 1'b0;
            endcase
        end
        return live;
    endfunction

endpackage

// File: rtl/lutram_lane.sv
module lutram_lane #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned NRD   = 4,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic                    wbit,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0]          rbit
);

    logic cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wbit;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rbit[p] = cells[raddr[p]];
    end

endmodule

// File: rtl/lutram_port_gate.sv
module lutram_port_gate #(
    parameter int unsigned W = 4
) (
    input  logic         live,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_out
);

    always_comb begin
        word_out = live ? word_in : '0;
    end

endmodule

// File: rtl/lutram_multiport.sv
module lutram_multiport
    import lutram_pkg::*;
#(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [1:0]    cfg,
    input  logic          we_a,
    input  logic [AW-1:0] addr_a,
    input  logic [W-1:0]  din_a,
    output logic [W-1:0]  dout_a,
    input  logic [AW-1:0] addr_b,
    output logic [W-1:0]  dout_b,
    input  logic [AW-1:0] addr_c,
    output logic [W-1:0]  dout_c,
    input  logic [AW-1:0] addr_d,
    output logic [W-1:0]  dout_d
);

    cfg_e                                cfg_q;
    logic [NUM_PORTS-1:0][AW-1:0]        rd_addr;
    logic [W-1:0][NUM_PORTS-1:0]         lane_bits;
    logic [NUM_PORTS-1:0][W-1:0]         raw_word;
    logic [NUM_PORTS-1:0][W-1:0]         gated_word;

    assign cfg_q      = cfg_e'(cfg);
    assign rd_addr[0] = addr_a;
    assign rd_addr[1] = addr_b;
    assign rd_addr[2] = addr_c;
    assign rd_addr[3] = addr_d;

    for (genvar i = 0; i < W; i++) begin : g_lane
        lutram_lane #(
            .DEPTH (DEPTH),
            .NRD   (NUM_PORTS)
        ) u_lane (
            .clk   (clk),
            .we    (we_a),
            .waddr (addr_a),
            .wbit  (din_a[i]),
            .raddr (rd_addr),
            .rbit  (lane_bits[i])
        );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign raw_word[p][i] = lane_bits[i][p];
        end
        lutram_port_gate #(
            .W (W)
        ) u_gate (
            .live     (port_live(cfg_q, p)),
            .word_in  (raw_word[p]),
            .word_out (gated_word[p])
        );
    end

    assign dout_a = gated_word[0];
    assign dout_b = gated_word[1];
    assign dout_c = gated_word[2];
    assign dout_d = gated_word[3];

endmodule

// File: rtl/lutram_multiport_chk.sv
module lutram_multiport_chk #(
    parameter int unsigned W  = 4,
    parameter int unsigned AW = 6
) (
    input logic          clk,
    input logic [1:0]    cfg,
    input logic          we_a,
    input logic [AW-1:0] addr_a,
    input logic [W-1:0]  din_a,
    input logic [W-1:0]  dout_a,
    input logic [AW-1:0] addr_b,
    input logic [W-1:0]  dout_b,
    input logic [AW-1:0] addr_c,
    input logic [W-1:0]  dout_c,
    input logic [AW-1:0] addr_d,
    input logic [W-1:0]  dout_d
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    assert_write_visible_a_R2: assert property (@(posedge clk) disable iff (!armed)
        we_a |=> ((addr_a != $past(addr_a)) || (dout_a == $past(din_a))));

    assert_write_visible_b_R5: assert property (@(posedge clk) disable iff (!armed)
        (we_a && cfg == 2'b10 && addr_b == addr_a) |=>
            ((cfg != 2'b10) || (addr_b != $past(addr_b)) || (dout_b == $past(din_a))));

    assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!armed)
        (!we_a && cfg == 2'b10) |=>
            ((cfg != 2'b10) || (addr_c != $past(addr_c)) || $stable(dout_c)));

    assert_single_quiet_R6: assert property (@(posedge clk) disable iff (!armed)
        (cfg == 2'b00 || cfg == 2'b11) |-> (dout_b == '0 && dout_c == '0 && dout_d == '0));

    assert_dual_quiet_R7: assert property (@(posedge clk) disable iff (!armed)
        (cfg == 2'b01) |-> (dout_c == '0 && dout_d == '0));

    assert_ports_agree_R8: assert property (@(posedge clk) disable iff (!armed)
        (cfg == 2'b10 && addr_c == addr_d) |-> (dout_c == dout_d));

endmodule

bind lutram_multiport lutram_multiport_chk #(.W(W), .AW(AW)) u_chk (
    .clk    (clk),
    .cfg    (cfg),
    .we_a   (we_a),
    .addr_a (addr_a),
    .din_a  (din_a),
    .dout_a (dout_a),
    .addr_b (addr_b),
    .dout_b (dout_b),
    .addr_c (addr_c),
    .dout_c (dout_c),
    .addr_d (addr_d),
    .dout_d (dout_d)
);

// File: tb/lutram_multiport_test.sv
module lutram_multiport_test;

    localparam int W  = 4;
    localparam int AW = 6;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic [1:0]    cfg = 2'b10;
    logic          we_a = 1'b0;
    logic [AW-1:0] addr_a = '0, addr_b = '0, addr_c = '0, addr_d = '0;
    logic [W-1:0]  din_a = '0;
    logic [W-1:0]  dout_a, dout_b, dout_c, dout_d;

    logic [W-1:0]  model [DEPTH];
    int            errors = 0;
    int            checks = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    lutram_multiport #(.W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .cfg(cfg), .we_a(we_a),
        .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
        .addr_b(addr_b), .dout_b(dout_b),
        .addr_c(addr_c), .dout_c(dout_c),
        .addr_d(addr_d), .dout_d(dout_d)
    );

    function automatic logic [W-1:0] pat(int a, int salt);
        return W'((a * 5 + salt * 3 + (a >> 2)) & 15);
    endfunction

    function automatic bit live(logic [1:0] c, int p);
        if (p == 0) return 1'b1;
        if (c == 2'b01) return p == 1;
        if (c == 2'b10) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write(int a, logic [W-1:0] d);
        @(negedge clk);
        we_a = 1'b1; addr_a = AW'(a); din_a = d;
        @(negedge clk);
        we_a = 1'b0;
        model[a] = d;
    endtask

    task automatic sweep(string req, int salt);
        for (int a = 0; a < DEPTH; a++) begin
            addr_a = AW'(a);
            addr_b = AW'(a ^ 21);
            addr_c = AW'(63 - a);
            addr_d = AW'((a + salt + 7) & 63);
            #1;
            check({req, " R1 R4 R10 A"}, dout_a, model[a]);
            check({req, " B"}, dout_b, live(cfg, 1) ? model[a ^ 21] : '0);
            check({req, " C"}, dout_c, live(cfg, 2) ? model[63 - a] : '0);
            check({req, " D"}, dout_d, live(cfg, 3) ? model[(a + salt + 7) & 63] : '0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] old_v, new_v;
        repeat (2) @(negedge clk);

        // R6 R7 R8 R9: fill and sweep under every configuration
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            cfg = 2'(m);
            for (int a = 0; a < DEPTH; a++) write(a, pat(a, m));
            case (m)
                0: sweep("R6 single", m);
                1: sweep("R7 dual", m);
                2: sweep("R8 quad", m);
                default: sweep("R9 reserved", m);
            endcase
        end

        // R11: write in quad, switch config, contents kept
        @(negedge clk); cfg = 2'b10;
        for (int a = 0; a < DEPTH; a++) write(a, pat(a, 9));
        @(negedge clk); cfg = 2'b00;
        sweep("R11 after switch to single", 9);
        @(negedge clk); cfg = 2'b10;
        sweep("R11 back to quad", 9);

        // R3: no enable, edges pass, data unchanged
        @(negedge clk);
        we_a = 1'b0; addr_a = 6'd10; din_a = ~model[10]; addr_c = 6'd10;
        repeat (3) @(posedge clk);
        #1;
        check("R3 hold A", dout_a, model[10]);
        check("R3 hold C", dout_c, model[10]);

        // R5 R2: same-address read during write
        @(negedge clk);
        old_v = model[33];
        new_v = ~old_v;
        addr_a = 6'd33; addr_b = 6'd33; addr_c = 6'd33; addr_d = 6'd34;
        din_a = new_v; we_a = 1'b1;
        #1;
        check("R5 before edge B", dout_b, old_v);
        check("R5 before edge A", dout_a, old_v);
        @(posedge clk); #1;
        model[33] = new_v;
        check("R5 after edge B", dout_b, new_v);
        check("R2 after edge C", dout_c, new_v);
        check("R2 neighbour untouched D", dout_d, model[34]);
        @(negedge clk); we_a = 1'b0;

        // R4: address change without clock
        addr_b = 6'd34; #1;
        check("R4 comb B", dout_b, model[34]);
        addr_b = 6'd33; #1;
        check("R4 comb B back", dout_b, new_v);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule